// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block gives a small processor hardware breakpoints on instruction addresses and a shared path for its two software break instructions. It holds a build-time number of breakpoint address slots and one arm register. It compares each valid fetch PC against every armed slot. Decode also tells it when the current instruction is a full-width or a narrow break instruction. When a trigger fires, the block raises a one-cycle debug exception request. That request carries a one-hot cause, the index of the matching slot and the PC of the offending instruction.

Software reaches the registers through a plain special-register port. Select 0 is the arm register, and select 1+i is the address of slot i. Writes complete in one clock, and reads are combinational. The pipeline treats the exception request as a redirect: the instruction that follows the offending one must not complete. Every trigger is qualified by a global debug-enable input. While that input is low, address slots never fire and break instructions behave as no-ops. None of the block's interfaces carry a data stream, so every pin is a plain control or status pin with no back-pressure.

Top module: `ibrk_unit`

## Requirements
- R1: After reset, the arm register and all slot addresses read as zero, and `exc_valid` is low.
- R2: Select 0 reads and writes the arm register, in which bit i arms slot i. Arm bits at or above NUM_SLOTS read as zero. Select 1+i reads and writes the address of slot i. A read of any other select returns zero.
- R3: A write to a select above NUM_SLOTS changes no register and causes no exception.
- R4: Slot i triggers only when its arm bit is set, `pc_valid` is high and its address equals `pc` exactly.
- R5: When several armed slots match, the lowest index wins, and `exc_slot` reports that index.
- R6: While `dbg_en` is low, neither address matches nor break instructions raise an exception.
- R7: The cause bits are one-hot. Bit 0 means address match, bit 1 means full-width break, and bit 2 means narrow break. If both break strobes are high, bit 1 is reported.
- R8: An address match on the same instruction as a break strobe reports only cause bit 0.
- R9: `exc_valid` is a one-cycle pulse in the cycle after the `pc_valid` cycle of the offending instruction, and `exc_pc` holds that instruction's PC. Without `pc_valid`, no exception is raised.
- R10: A register write in the same cycle as a `pc_valid` instruction does not affect that instruction's comparison. It applies from the next instruction onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Special-register write strobe |
| wr_sel | input | SEL_W | Write select: 0 is the arm register, 1+i is slot i |
| wr_data | input | ADDR_W | Write data |
| rd_sel | input | SEL_W | Read select |
| rd_data | output | ADDR_W | Combinational read data |
| dbg_en | input | 1 | Global debug enable |
| pc_valid | input | 1 | An instruction is about to execute at `pc` |
| pc | input | ADDR_W | PC of that instruction |
| brk_wide | input | 1 | Decode: full-width break instruction |
| brk_narrow | input | 1 | Decode: narrow break instruction |
| exc_valid | output | 1 | Debug exception request (one-cycle pulse) |
| exc_cause | output | 3 | One-hot cause |
| exc_slot | output | IDX_W | Matching slot index (0 unless cause bit 0) |
| exc_pc | output | ADDR_W | PC of the offending instruction |

## Verification
The exception outputs are registered, so each result is due on the first clock edge after the `pc_valid` cycle. The bench drives an instruction on a falling edge and samples the exception outputs on the next falling edge. It then samples once more a cycle later to confirm the pulse has dropped. A register write lands on the edge that ends its strobe cycle, and reads are combinational, so each readback is sampled a short delay after `rd_sel` changes. The same-cycle write case drives the write and the instruction on the same falling edge, so that the outcome shows the old register state.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
  localparam int CAUSE_W  = 3;
  localparam int CAUSE_IB = 0;  // address slot match
  localparam int CAUSE_BI = 1;  // full-width break instruction
  localparam int CAUSE_BN = 2;  // narrow break instruction
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs #(
  parameter int NUM_SLOTS = 2,
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [ADDR_W-1:0]           wr_data,
  input  logic [SEL_W-1:0]            rd_sel,
  output logic [ADDR_W-1:0]           rd_data,
  output logic [NUM_SLOTS-1:0]        arm,
  output logic [NUM_SLOTS*ADDR_W-1:0] addr_flat
);
  logic [NUM_SLOTS-1:0] arm_q;
  logic [ADDR_W-1:0]    addr_q [NUM_SLOTS];

  // arm register lives at select 0
  always_ff @(posedge clk) begin
    if (!rst_n)                          arm_q <= '0;
    else if (wr_en && wr_sel == '0)      arm_q <= wr_data[NUM_SLOTS-1:0];
  end

  // one address register per implemented slot; other selects fall through
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   addr_q[i] <= '0;
      else if (wr_en && wr_sel == SEL_W'(i + 1))    addr_q[i] <= wr_data;
    end
    assign addr_flat[i*ADDR_W +: ADDR_W] = addr_q[i];
  end

  assign arm = arm_q;

  always_comb begin
    rd_data = '0;
    if (rd_sel == '0) rd_data[NUM_SLOTS-1:0] = arm_q;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (rd_sel == SEL_W'(i + 1)) rd_data = addr_q[i];
  end

  // R3: writes past the last slot leave all state untouched
  a_r3_oob_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_sel) > NUM_SLOTS) |=> ($stable(addr_flat) && $stable(arm)));
  // R2: arm bits are only written through select 0
  a_r2_arm_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == '0) |=> $stable(arm));
endmodule

// File: rtl/ibrk_match.sv
module ibrk_match #(
  parameter int NUM_SLOTS = 2,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           pc,
  input  logic [NUM_SLOTS-1:0]        arm,
  input  logic [NUM_SLOTS*ADDR_W-1:0] addr_flat,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [NUM_SLOTS-1:0] eq;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign eq[i] = arm[i] && (addr_flat[i*ADDR_W +: ADDR_W] == pc);
  end

  // scan from the top down so the lowest matching index is the last written
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // R5: the reported slot is armed, matches, and no lower slot matches
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (eq[hit_idx] && ((eq & ((NUM_SLOTS'(1) << hit_idx) - NUM_SLOTS'(1))) == '0)));
  // R4: a disarmed slot never produces the hit
  a_r4_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> arm[hit_idx]);
endmodule

// File: rtl/ibrk_report.sv
module ibrk_report
  import ibrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              brk_wide,
  input  logic              brk_narrow,
  input  logic              hit,
  input  logic [IDX_W-1:0]  hit_idx,
  output logic              exc_valid,
  output cause_t            exc_cause,
  output logic [IDX_W-1:0]  exc_slot,
  output logic [ADDR_W-1:0] exc_pc
);
  logic   live;
  cause_t nxt_cause;

  assign live = dbg_en && pc_valid;

  // address match outranks the wide break, which outranks the narrow one
  always_comb begin
    nxt_cause = '0;
    if (live) begin
      if (hit)             nxt_cause[CAUSE_IB] = 1'b1;
      else if (brk_wide)   nxt_cause[CAUSE_BI] = 1'b1;
      else if (brk_narrow) nxt_cause[CAUSE_BN] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_cause <= '0;
      exc_slot  <= '0;
      exc_pc    <= '0;
    end else begin
      exc_valid <= |nxt_cause;
      exc_cause <= nxt_cause;
      if (|nxt_cause) begin
        exc_pc   <= pc;
        exc_slot <= nxt_cause[CAUSE_IB] ? hit_idx : '0;
      end
    end
  end

  // R6 / R9: nothing fires without debug enable and a valid instruction
  a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_en && pc_valid) |=> !exc_valid);
  // R7: exactly one cause bit per request
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> ($countones(exc_cause) == 1));
  // R9: reported PC is the instruction presented one cycle earlier
  a_r9_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_en && pc_valid && (hit || brk_wide || brk_narrow)) |=> (exc_valid && exc_pc == $past(pc)));
  // R8: an address match suppresses both break causes
  a_r8_ib_first: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_en && pc_valid && hit) |=> exc_cause[CAUSE_IB]);
endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
  import ibrk_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 4,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              dbg_en,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc,
  input  logic              brk_wide,
  input  logic              brk_narrow,
  output logic              exc_valid,
  output logic [2:0]        exc_cause,
  output logic [IDX_W-1:0]  exc_slot,
  output logic [ADDR_W-1:0] exc_pc
);
  logic [NUM_SLOTS-1:0]        arm;
  logic [NUM_SLOTS*ADDR_W-1:0] addr_flat;
  logic                        hit;
  logic [IDX_W-1:0]            hit_idx;
  cause_t                      cause_q;

  ibrk_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .arm(arm), .addr_flat(addr_flat));

  ibrk_match #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst_n(rst_n), .pc(pc), .arm(arm), .addr_flat(addr_flat),
    .hit(hit), .hit_idx(hit_idx));

  ibrk_report #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_report (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .pc_valid(pc_valid), .pc(pc),
    .brk_wide(brk_wide), .brk_narrow(brk_narrow), .hit(hit), .hit_idx(hit_idx),
    .exc_valid(exc_valid), .exc_cause(cause_q), .exc_slot(exc_slot), .exc_pc(exc_pc));

  assign exc_cause = cause_q;

  // R9: request is a single-cycle pulse unless a new instruction re-fires it
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !pc_valid) |=> !exc_valid);
endmodule

// File: tb/ibrk_unit_test.sv
module ibrk_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        dbg_en = 1'b1;
  logic        pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic        brk_wide = 1'b0;
  logic        brk_narrow = 1'b0;
  logic        exc_valid;
  logic [2:0]  exc_cause;
  logic [0:0]  exc_slot;
  logic [31:0] exc_pc;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibrk_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .dbg_en(dbg_en), .pc_valid(pc_valid),
    .pc(pc), .brk_wide(brk_wide), .brk_narrow(brk_narrow), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .exc_slot(exc_slot), .exc_pc(exc_pc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] s, input logic [31:0] exp);
    rd_sel = s; #1;
    chk(req, rd_data, exp);
  endtask

  // present one instruction, then check the registered request one cycle later
  task automatic fire(input string req, input logic [31:0] p, input logic w, input logic n,
                      input logic ev, input logic [2:0] ec, input logic es);
    @(negedge clk); pc_valid = 1'b1; pc = p; brk_wide = w; brk_narrow = n;
    @(negedge clk); pc_valid = 1'b0; brk_wide = 1'b0; brk_narrow = 1'b0;
    chk(req, {31'b0, exc_valid}, {31'b0, ev});
    if (ev) begin
      chk(req, {29'b0, exc_cause}, {29'b0, ec});
      chk(req, {31'b0, exc_slot}, {31'b0, es});
      chk(req, exc_pc, p);
    end
  endtask

  task automatic t_reset;
    chk("R1 exc_valid", {31'b0, exc_valid}, 32'h0);
    rd_chk("R1 arm", 4'd0, 32'h0);
    rd_chk("R1 slot0", 4'd1, 32'h0);
    rd_chk("R1 slot1", 4'd2, 32'h0);
  endtask

  task automatic t_regmap;
    wr(4'd0, 32'hFFFF_FFFF);
    rd_chk("R2 arm upper bits zero", 4'd0, 32'h3);
    wr(4'd1, 32'h1234_5678);
    wr(4'd2, 32'h8765_4320);
    rd_chk("R2 slot0", 4'd1, 32'h1234_5678);
    rd_chk("R2 slot1", 4'd2, 32'h8765_4320);
    rd_chk("R2 unimpl sel3", 4'd3, 32'h0);
    rd_chk("R2 unimpl sel15", 4'd15, 32'h0);
  endtask

  task automatic t_oob;
    wr(4'd3, 32'hDEAD_BEEF);
    wr(4'd15, 32'hCAFE_0000);
    rd_chk("R3 slot0 kept", 4'd1, 32'h1234_5678);
    rd_chk("R3 slot1 kept", 4'd2, 32'h8765_4320);
    rd_chk("R3 arm kept", 4'd0, 32'h3);
    rd_chk("R3 sel3 still zero", 4'd3, 32'h0);
    fire("R3 no trigger at dropped addr", 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0);
  endtask

  task automatic t_arm;
    wr(4'd1, 32'h0000_0100);
    wr(4'd2, 32'h0000_0500);
    wr(4'd0, 32'h0);
    fire("R4 disarmed slot", 32'h100, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0);
    wr(4'd0, 32'h1);
    fire("R4 armed match", 32'h100, 1'b0, 1'b0, 1'b1, 3'b001, 1'b0);
    fire("R4 near miss", 32'h104, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0);
    fire("R4 slot1 disarmed", 32'h500, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0);
  endtask

  task automatic t_priority;
    wr(4'd1, 32'h200);
    wr(4'd2, 32'h200);
    wr(4'd0, 32'h3);
    fire("R5 lowest slot wins", 32'h200, 1'b0, 1'b0, 1'b1, 3'b001, 1'b0);
    wr(4'd0, 32'h2);
    fire("R5 slot1 alone", 32'h200, 1'b0, 1'b0, 1'b1, 3'b001, 1'b1);
  endtask

  task automatic t_breaks;
    fire("R7 wide break", 32'h700, 1'b1, 1'b0, 1'b1, 3'b010, 1'b0);
    fire("R7 narrow break", 32'h704, 1'b0, 1'b1, 1'b1, 3'b100, 1'b0);
    fire("R7 both strobes", 32'h708, 1'b1, 1'b1, 1'b1, 3'b010, 1'b0);
    fire("R8 match beats break", 32'h200, 1'b1, 1'b1, 1'b1, 3'b001, 1'b1);
  endtask

  task automatic t_gate;
    @(negedge clk); dbg_en = 1'b0;
    fire("R6 match gated", 32'h200, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0);
    fire("R6 break gated", 32'h720, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0);
    @(negedge clk); dbg_en = 1'b1;
  endtask

  task automatic t_pulse;
    fire("R9 request", 32'h200, 1'b0, 1'b0, 1'b1, 3'b001, 1'b1);
    @(negedge clk);
    chk("R9 pulse drops", {31'b0, exc_valid}, 32'h0);
    @(negedge clk); pc = 32'h200; brk_wide = 1'b1; pc_valid = 1'b0;
    @(negedge clk); brk_wide = 1'b0;
    chk("R9 no pc_valid", {31'b0, exc_valid}, 32'h0);
  endtask

  task automatic t_same_cycle;
    wr(4'd1, 32'h300);
    wr(4'd0, 32'h1);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd0; wr_data = 32'h0;
    pc_valid = 1'b1; pc = 32'h300;
    @(negedge clk);
    wr_en = 1'b0; pc_valid = 1'b0;
    chk("R10 old arm used", {31'b0, exc_valid}, 32'h1);
    chk("R10 cause", {29'b0, exc_cause}, 32'h1);
    fire("R10 new arm applies", 32'h300, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_oob();
    t_arm();
    t_priority();
    t_breaks();
    t_gate();
    t_pulse();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule